// File: doc/BRIEF.md
# Masked stream channel deinterleaver

This block takes a packed stream of samples on a valid/ready input port and spreads it over a fixed set of output ports. Each output channel has an enable bit. Only enabled channels draw samples from the stream, so the stream carries no filler for disabled channels. Each channel owns `SPC` adjacent ports, one per sample slot. One input beat holds exactly one word for each port.

The output side behaves like the read side of a multi-port FIFO. A single read request serves every channel. The cycle after a request, the block answers with either a valid strobe, with all enabled ports loaded, or an underflow strobe. When the enabled channels use fewer samples than a beat carries, the surplus stays in an internal store and is used before any new beat is taken. A beat is pulled only when the store alone cannot cover the request.

The enable mask is set while synchronous reset is held. Reset empties the store.

Top module: `upk_deinterleave`

## Requirements
- R1: An input beat is taken only in a cycle with both `in_valid` and `in_ready` high. `in_ready` is high exactly when `rst` is low, `rd_req` is high and the store holds fewer samples than one read needs. One read needs (number of enabled channels) × SPC samples.
- R2: A request that the store can cover, or that coincides with an accepted beat, gives `rd_valid` high in the next cycle.
- R3: In a `rd_valid` cycle, consumed samples land in slot-major order. For slot h from 0 up, each enabled channel c in ascending order takes the next stream sample, on port c×SPC+h. Port p occupies bits p×SW upward of `rd_data`. Within a beat, the sample in bits k×SW upward comes earlier in the stream than the sample at k+1.
- R4: A request that the store cannot cover, made while `in_valid` is low, gives `rd_underflow` high in the next cycle and consumes nothing.
- R5: `rd_valid` and `rd_underflow` are never high together. Neither is high unless `rd_req` was high in the previous cycle.
- R6: Samples left over from a beat are kept in stream order and delivered by later reads before any sample of a newer beat.
- R7: Every enable mask works, including all channels enabled. With no channel enabled, every request is answered with `rd_valid` and `in_ready` stays low.
- R8: Synchronous active-high reset empties the store and clears `rd_valid` and `rd_underflow` on the next edge. It holds `in_ready` low while asserted.
- R9: Leftover samples from one beat can be combined with the start of the next beat in a single read, with no sample lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | NUM_CH | Per-channel enable mask, changed only during reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block takes the offered beat |
| in_data | input | NUM_CH*SPC*SW | Packed input samples, sample 0 in the low bits |
| rd_req | input | 1 | Shared read request for all ports |
| rd_valid | output | 1 | Previous request served, enabled ports hold data |
| rd_underflow | output | 1 | Previous request could not be served |
| rd_data | output | NUM_CH*SPC*SW | Output port words, port p at bits p*SW upward |

## Verification
The hardest case to reach is a read whose samples come partly from the store and partly from a freshly accepted beat. It needs a leftover count that is non-zero but below the per-read need, and that count depends on the mask and on the whole history of reads. The stimulus walks every enable mask with SPC=2. Under each mask it runs a stretch of back-to-back requests with beats always offered, then a stretch where requests and beat offers are random. Odd enabled-channel counts then drift the store through every fill level. A final stretch requests with no beat offered, to force underflows at each fill level.

// File: rtl/upk_pkg.sv
package upk_pkg;

   localparam int unsigned MAX_CH = 32;

   function automatic int unsigned ones_below(input logic [MAX_CH-1:0] mask,
                                              input int unsigned limit);
      int unsigned n;
      n = 0;
      for (int i = 0; i < MAX_CH; i++) begin
         if (i < limit && mask[i]) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/upk_lane_map.sv
module upk_lane_map #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned SPC    = 2,
   parameter int unsigned IW     = 4,
   parameter int unsigned CW     = 5
) (
   input  logic [NUM_CH-1:0]                   chan_en,
   output logic [NUM_CH*SPC-1:0][IW-1:0]       port_idx,
   output logic [NUM_CH*SPC-1:0]               port_on,
   output logic [CW-1:0]                       need
);
   import upk_pkg::*;

   logic [CW-1:0] en_cnt;

   always_comb begin
      en_cnt = CW'(ones_below(MAX_CH'(chan_en), NUM_CH));
      need   = CW'(en_cnt * CW'(SPC));
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CW-1:0] rank;
      assign rank = CW'(ones_below(MAX_CH'(chan_en), c));
      for (genvar h = 0; h < SPC; h++) begin : g_slot
         localparam int unsigned P = c * SPC + h;
         assign port_on[P] = chan_en[c];
         if (SPC == 1) begin : g_single
            assign port_idx[P] = IW'(rank);
         end else begin : g_multi
            assign port_idx[P] = IW'(CW'(h) * en_cnt + rank);
         end
      end
   end

   always_comb begin
      for (int p = 0; p < NUM_CH * SPC; p++) begin
         assert (!port_on[p] || port_idx[p] < need)
            else $error("p_idx_in_need_r3: port index beyond need");
      end
   end

endmodule

// File: rtl/upk_sample_store.sv
module upk_sample_store #(
   parameter int unsigned NP = 8,
   parameter int unsigned SW = 8,
   parameter int unsigned CW = 5
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NP-1:0][SW-1:0]       beat,
   input  logic                        load,
   input  logic                        take,
   input  logic [CW-1:0]               need,
   output logic [2*NP-1:0][SW-1:0]     win,
   output logic [CW-1:0]               cnt
);
   localparam int unsigned WN = 2 * NP;

   logic [NP-1:0][SW-1:0] stor_q;
   logic [CW-1:0]         cnt_q;

   assign cnt = cnt_q;

   always_comb begin
      for (int k = 0; k < WN; k++) begin
         win[k] = '0;
         if (k < NP && k < int'(cnt_q)) begin
            win[k] = stor_q[k];
         end else if (k >= int'(cnt_q) && (k - int'(cnt_q)) < NP) begin
            win[k] = beat[k - int'(cnt_q)];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else begin
         if (take) begin
            for (int k = 0; k < NP; k++) begin
               if (k + int'(need) < WN) stor_q[k] <= win[k + int'(need)];
            end
         end
         cnt_q <= cnt_q + (load ? CW'(NP) : CW'(0)) - (take ? need : CW'(0));
      end
   end

   p_store_bound_r6: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CW'(NP))
      else $error("p_store_bound_r6");

   p_load_when_short_r1: assert property (@(posedge clk) disable iff (rst)
      load |-> (cnt_q < need && take))
      else $error("p_load_when_short_r1");

   p_take_covered_r9: assert property (@(posedge clk) disable iff (rst)
      take |-> (int'(cnt_q) + (load ? NP : 0) >= int'(need)))
      else $error("p_take_covered_r9");

endmodule

// File: rtl/upk_port_router.sv
module upk_port_router #(
   parameter int unsigned NP = 8,
   parameter int unsigned SW = 8,
   parameter int unsigned IW = 4
) (
   input  logic                        clk,
   input  logic                        fire,
   input  logic [2*NP-1:0][SW-1:0]     win,
   input  logic [NP-1:0][IW-1:0]       port_idx,
   input  logic [NP-1:0]               port_on,
   output logic [NP-1:0][SW-1:0]       data_q
);
   for (genvar p = 0; p < NP; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (fire && port_on[p]) data_q[p] <= win[port_idx[p]];
      end
   end

endmodule

// File: rtl/upk_deinterleave.sv
module upk_deinterleave #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned SPC    = 2,
   parameter int unsigned SW     = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_CH-1:0]         chan_en,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [NUM_CH*SPC*SW-1:0]  in_data,
   input  logic                      rd_req,
   output logic                      rd_valid,
   output logic                      rd_underflow,
   output logic [NUM_CH*SPC*SW-1:0]  rd_data
);
   localparam int unsigned NP = NUM_CH * SPC;
   localparam int unsigned IW = $clog2(2 * NP);
   localparam int unsigned CW = $clog2(2 * NP + 1);

   if (NUM_CH < 1 || NUM_CH > upk_pkg::MAX_CH) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (SPC < 1) begin : g_bad_spc
      $error("SPC must be at least 1");
   end
   if (SW < 1) begin : g_bad_sw
      $error("SW must be at least 1");
   end

   logic [NP-1:0][IW-1:0]   port_idx;
   logic [NP-1:0]           port_on;
   logic [CW-1:0]           need;
   logic [CW-1:0]           cnt;
   logic [2*NP-1:0][SW-1:0] win;
   logic [NP-1:0][SW-1:0]   beat;
   logic [NP-1:0][SW-1:0]   data_q;
   logic                    enough, load, take, starve;
   logic                    valid_q, uf_q;

   assign beat = in_data;

   upk_lane_map #(.NUM_CH(NUM_CH), .SPC(SPC), .IW(IW), .CW(CW)) u_map (
      .chan_en (chan_en),
      .port_idx(port_idx),
      .port_on (port_on),
      .need    (need)
   );

   upk_sample_store #(.NP(NP), .SW(SW), .CW(CW)) u_store (
      .clk (clk),
      .rst (rst),
      .beat(beat),
      .load(load),
      .take(take),
      .need(need),
      .win (win),
      .cnt (cnt)
   );

   upk_port_router #(.NP(NP), .SW(SW), .IW(IW)) u_route (
      .clk     (clk),
      .fire    (take),
      .win     (win),
      .port_idx(port_idx),
      .port_on (port_on),
      .data_q  (data_q)
   );

   always_comb begin
      enough   = (cnt >= need);
      in_ready = !rst && rd_req && !enough;
      load     = in_valid && in_ready;
      take     = !rst && rd_req && (enough || in_valid);
      starve   = !rst && rd_req && !enough && !in_valid;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         uf_q    <= 1'b0;
      end else begin
         valid_q <= take;
         uf_q    <= starve;
      end
   end

   assign rd_valid     = valid_q;
   assign rd_underflow = uf_q;
   assign rd_data      = data_q;

   p_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(rd_valid && rd_underflow))
      else $error("p_excl_r5");

   p_resp_after_req_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_valid || rd_underflow) |-> $past(rd_req))
      else $error("p_resp_after_req_r5");

   p_ready_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> rd_req)
      else $error("p_ready_needs_req_r1");

   p_beat_gives_valid_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_req && in_ready && in_valid) |=> rd_valid)
      else $error("p_beat_gives_valid_r2");

   p_starve_underflow_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_req && in_ready && !in_valid) |=> rd_underflow)
      else $error("p_starve_underflow_r4");

   p_no_req_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      !rd_req |=> !(rd_valid || rd_underflow))
      else $error("p_no_req_quiet_r5");

endmodule

// File: tb/tb_upk_deinterleave.sv
module tb_upk_deinterleave;
   localparam int NUM_CH = 4;
   localparam int SPC    = 2;
   localparam int SW     = 8;
   localparam int NP     = NUM_CH * SPC;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NUM_CH-1:0] chan_en = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [NP*SW-1:0]  in_data = '0;
   logic              rd_req = 1'b0;
   logic              rd_valid, rd_underflow;
   logic [NP*SW-1:0]  rd_data;

   always #2 clk = ~clk;

   upk_deinterleave #(.NUM_CH(NUM_CH), .SPC(SPC), .SW(SW)) dut (
      .clk(clk), .rst(rst), .chan_en(chan_en),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_underflow(rd_underflow),
      .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int q[$];
   int seq = 0;
   bit exp_valid = 0, exp_uf = 0;
   int exp_data[NP];
   bit exp_on[NP];

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int need_of(input logic [NUM_CH-1:0] m);
      int n = 0;
      for (int c = 0; c < NUM_CH; c++) if (m[c]) n++;
      return n * SPC;
   endfunction

   task automatic load_beat();
      for (int k = 0; k < NP; k++) in_data[k*SW +: SW] = SW'(seq + k);
   endtask

   // compare registered outputs, then drive, then model this edge
   task automatic step(input bit req, input bit val);
      int need;
      bit exp_rdy;
      @(negedge clk);
      check(rd_valid == exp_valid, "R2 rd_valid", int'(rd_valid), int'(exp_valid));
      check(rd_underflow == exp_uf, "R4 rd_underflow", int'(rd_underflow), int'(exp_uf));
      if (exp_valid && rd_valid) begin
         for (int p = 0; p < NP; p++) begin
            if (exp_on[p])
               check(int'(rd_data[p*SW +: SW]) == exp_data[p], "R3 R6 R9 port data",
                     int'(rd_data[p*SW +: SW]), exp_data[p]);
         end
      end
      rd_req = req;
      in_valid = val;
      load_beat();
      #1;
      need = need_of(chan_en);
      exp_rdy = req && (q.size() < need);
      check(in_ready == exp_rdy, "R1 R7 in_ready", int'(in_ready), int'(exp_rdy));
      exp_valid = 0;
      exp_uf = 0;
      if (req) begin
         if (exp_rdy && val) begin
            for (int k = 0; k < NP; k++) q.push_back((seq + k) % (1 << SW));
            seq += NP;
         end
         if (q.size() >= need) begin
            exp_valid = 1;
            for (int h = 0; h < SPC; h++)
               for (int c = 0; c < NUM_CH; c++)
                  if (chan_en[c]) exp_data[c*SPC+h] = q.pop_front();
         end else begin
            exp_uf = 1;
         end
      end
   endtask

   task automatic restart(input logic [NUM_CH-1:0] m);
      @(negedge clk);
      rst = 1'b1;
      rd_req = 1'b1;
      in_valid = 1'b1;
      chan_en = m;
      #1;
      check(in_ready == 1'b0, "R8 ready low in reset", int'(in_ready), 0);
      @(negedge clk);
      check(rd_valid == 1'b0 && rd_underflow == 1'b0, "R8 strobes cleared",
            int'({rd_valid, rd_underflow}), 0);
      rst = 1'b0;
      rd_req = 1'b0;
      in_valid = 1'b0;
      q.delete();
      exp_valid = 0;
      exp_uf = 0;
      for (int p = 0; p < NP; p++) exp_on[p] = m[p / SPC];
   endtask

   initial begin
      repeat (3) @(posedge clk);
      // directed: starve straight after reset, then one beat (R4, R2)
      restart(4'b0111);
      step(1, 0);
      step(1, 1);
      step(1, 0);
      step(0, 0);
      step(0, 0);
      for (int m = 0; m < (1 << NUM_CH); m++) begin
         restart(NUM_CH'(m));
         for (int i = 0; i < 20; i++) step(1, 1);
         for (int i = 0; i < 40; i++) step(1'($urandom), 1'($urandom));
         for (int i = 0; i < 6; i++) step(1, 0);
         step(0, 1);
         step(0, 0);
      end
      // all channels enabled, long run (R7)
      restart('1);
      for (int i = 0; i < 50; i++) step(1'($urandom), 1'($urandom));
      step(0, 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule